// File: doc/BRIEF.md
# Nibble Bit-Test Instruction Executor

This block runs one family of 13-bit instructions on a processor core with 4-bit data. Each instruction reads one data nibble, ANDs it with a 4-bit immediate carried in the opcode, and records only whether the result is zero. Memory is never written. The nibble's address comes from one of two 16-bit index registers, X or Y. The increment forms add one to the chosen register after the test.

A one-shot extension prefix can load an 8-bit operand ahead of an instruction. The next plain (non-increment) test then ignores the index register. It reads from page 0000H when X is selected, or from page FF00H when Y is selected, at the offset given by the operand. The increment forms ignore the prefix. Any accepted instruction uses up the prefix.

The memory read port is combinational, so each instruction is accepted and retired at one clock edge. Instructions can therefore arrive back to back.

Top module: `nib_bittest_exec`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is 1 and `instr_code[12:6]` equals 1101010b, which covers codes 1A80H to 1ABFH. Any other code, or a low `instr_valid`, leaves X, Y, Z and the pending prefix unchanged.
- R2: At the edge that accepts an instruction, `flag_z` becomes 1 if `mem_rdata & instr_code[3:0]` is 0000b, and becomes 0 otherwise. Because of this, back-to-back instructions each retire in one cycle.
- R3: With no prefix applied, `mem_addr` equals X when `instr_code[5]` is 0 and equals Y when it is 1. A plain form (`instr_code[4]` = 0) leaves both index registers unchanged.
- R4: An increment form (`instr_code[4]` = 1) adds one to the selected index register after the test. The register wraps from FFFFH to 0000H, and the other register is left unchanged.
- R5: When `ext_load` is 1 at an edge, `ext_pending` becomes 1 and `ext_operand` is captured as the prefix operand.
- R6: A plain form accepted while `ext_pending` is 1 reads `mem_addr` = 00H:operand for X, or FFH:operand for Y. Neither index register changes.
- R7: An increment form accepted while `ext_pending` is 1 ignores the prefix. It uses normal indirect addressing and performs the increment.
- R8: `ext_pending` clears at the edge that accepts any instruction. The exception is when `ext_load` is also 1 at that edge: the new prefix then stays pending, and the accepted instruction still uses the old prefix state.
- R9: A synchronous active-high `rst` clears X, Y, Z, the pending flag and the prefix operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction strobe |
| instr_code | input | 13 | Instruction word |
| ext_load | input | 1 | Loads the extension prefix |
| ext_operand | input | 8 | Prefix operand (page offset) |
| mem_addr | output | 16 | Data memory read address (combinational) |
| mem_rdata | input | 4 | Data nibble read at `mem_addr` |
| idx_x | output | 16 | X index register |
| idx_y | output | 16 | Y index register |
| flag_z | output | 1 | Zero flag |
| ext_pending | output | 1 | A prefix is waiting for the next instruction |

## Verification
The assertions check on every cycle that rejected codes leave all state untouched. They also check that Z follows the masked nibble read in the accepting cycle, that X increments with wrap, that the extended page is all zeros or all ones, and that the prefix is set and consumed correctly. Only the bench scenarios can show that all 64 codes decode properly against a memory model, and that the full 65536-step wrap of X completes. The bench scenarios also cover the prefix arriving in the same cycle as an instruction, and confirm that an increment form truly disregards a pending prefix.

// File: rtl/nib_bittest_exec.sv
module nib_bittest_exec #(
  parameter int IDX_W = 16,
  parameter int EXT_W = 8,
  parameter logic [6:0] OP_BASE = 7'b1101010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [12:0]      instr_code,
  input  logic             ext_load,
  input  logic [EXT_W-1:0] ext_operand,
  output logic [IDX_W-1:0] mem_addr,
  input  logic [3:0]       mem_rdata,
  output logic [IDX_W-1:0] idx_x,
  output logic [IDX_W-1:0] idx_y,
  output logic             flag_z,
  output logic             ext_pending
);
  localparam int PAGE_W = IDX_W - EXT_W;

  logic [EXT_W-1:0] ext_q;
  logic             hit, sel_y, inc, use_ext;
  logic [3:0]       imm;

  assign hit     = instr_valid && (instr_code[12:6] == OP_BASE);
  assign sel_y   = instr_code[5];
  assign inc     = instr_code[4];
  assign imm     = instr_code[3:0];
  assign use_ext = ext_pending && !inc;

  assign mem_addr = use_ext ? {{PAGE_W{sel_y}}, ext_q} : (sel_y ? idx_y : idx_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_x       <= '0;
      idx_y       <= '0;
      flag_z      <= 1'b0;
      ext_pending <= 1'b0;
      ext_q       <= '0;
    end else begin
      if (hit) begin
        flag_z <= ((mem_rdata & imm) == 4'b0000);
        if (inc) begin
          if (sel_y) idx_y <= idx_y + 1'b1;
          else       idx_x <= idx_x + 1'b1;
        end
      end
      if (ext_load) begin
        ext_pending <= 1'b1;
        ext_q       <= ext_operand;
      end else if (hit) begin
        ext_pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nib_bittest_exec_chk.sv
module nib_bittest_exec_chk #(
  parameter int IDX_W = 16,
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_valid,
  input logic [12:0]      instr_code,
  input logic             ext_load,
  input logic [IDX_W-1:0] mem_addr,
  input logic [3:0]       mem_rdata,
  input logic [IDX_W-1:0] idx_x,
  input logic [IDX_W-1:0] idx_y,
  input logic             flag_z,
  input logic             ext_pending
);
  logic acc;
  assign acc = instr_valid && (instr_code[12:6] == 7'b1101010);

  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (!acc && !ext_load) |=> ($stable(idx_x) && $stable(idx_y) && $stable(flag_z) && $stable(ext_pending)));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> (flag_z == (($past(mem_rdata) & $past(instr_code[3:0])) == 4'b0000)));

  p_plain_keeps_idx_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !instr_code[4]) |=> ($stable(idx_x) && $stable(idx_y)));

  p_x_increment_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && instr_code[4] && !instr_code[5]) |=> (idx_x == IDX_W'($past(idx_x) + 1'b1) && $stable(idx_y)));

  p_prefix_set_r5: assert property (@(posedge clk) disable iff (rst)
    ext_load |=> ext_pending);

  p_ext_page_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && ext_pending && !instr_code[4]) |->
      (instr_code[5] ? (&mem_addr[IDX_W-1:EXT_W]) : !(|mem_addr[IDX_W-1:EXT_W])));

  p_inc_ignores_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && instr_code[4]) |-> (mem_addr == (instr_code[5] ? idx_y : idx_x)));

  p_prefix_consumed_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !ext_load) |=> !ext_pending);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (idx_x == '0 && idx_y == '0 && !flag_z && !ext_pending));
endmodule

bind nib_bittest_exec nib_bittest_exec_chk #(.IDX_W(IDX_W), .EXT_W(EXT_W)) chk_i (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_code(instr_code),
  .ext_load(ext_load), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .idx_x(idx_x), .idx_y(idx_y), .flag_z(flag_z), .ext_pending(ext_pending)
);

// File: tb/nib_bittest_exec_tb.sv
module nib_bittest_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [12:0] instr_code = '0;
  logic        ext_load = 1'b0;
  logic [7:0]  ext_operand = '0;
  logic [15:0] mem_addr, idx_x, idx_y;
  logic [3:0]  mem_rdata;
  logic        flag_z, ext_pending;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [15:0] m_x = '0, m_y = '0;
  logic [7:0]  m_op = '0;
  logic        m_z = 1'b0, m_e = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [3:0] memf(input logic [15:0] a);
    return a[3:0] ^ a[7:4] ^ a[15:12] ^ 4'h5;
  endfunction

  assign mem_rdata = memf(mem_addr);

  nib_bittest_exec dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_code(instr_code),
    .ext_load(ext_load), .ext_operand(ext_operand), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .idx_x(idx_x), .idx_y(idx_y), .flag_z(flag_z),
    .ext_pending(ext_pending)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(idx_x == m_x, req, idx_x, m_x);
    check(idx_y == m_y, req, idx_y, m_y);
    check(flag_z == m_z, req, flag_z, m_z);
    check(ext_pending == m_e, req, ext_pending, m_e);
  endtask

  // one cycle starting at a negedge, ends at the next negedge
  task automatic step(input logic v, input logic [12:0] code, input logic el, input logic [7:0] eop);
    logic hit, inc, sy, ue;
    logic [15:0] ea;
    string tag;
    instr_valid = v; instr_code = code; ext_load = el; ext_operand = eop;
    hit = v && (code[12:6] == 7'b1101010);
    inc = code[4]; sy = code[5];
    ue  = m_e && !inc;
    ea  = ue ? {{8{sy}}, m_op} : (sy ? m_y : m_x);
    #1;
    if (hit) begin
      tag = ue ? "R6" : ((m_e && inc) ? "R7" : "R3");
      check(mem_addr == ea, tag, mem_addr, ea);
    end
    @(posedge clk);
    if (hit) begin
      m_z = ((memf(ea) & code[3:0]) == 4'b0000);
      if (inc) begin
        if (sy) m_y = m_y + 16'd1;
        else    m_x = m_x + 16'd1;
      end
    end
    if (el) begin m_e = 1'b1; m_op = eop; end
    else if (hit) m_e = 1'b0;
    @(negedge clk);
    if (!hit && !el)        tag = "R1";
    else if (hit && el)     tag = "R8";
    else if (el)            tag = "R5";
    else if (inc)           tag = (ue || m_e) ? "R7" : "R4";
    else                    tag = "R2";
    check_state(tag);
    instr_valid = 1'b0; ext_load = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check_state("R9");
    // raise Y so the two registers differ
    for (int i = 0; i < 37; i++) step(1'b1, 13'h1AB0 | 13'(i % 16), 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) step(1'b1, 13'h1A9F, 1'b0, 8'h00);
    // R1 R2 R3 R4: all 64 codes without prefix, twice
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 64; c++) step(1'b1, 13'h1A80 + 13'(c), 1'b0, 8'h00);
    // R5 R6 R7 R8: prefix before each code with varying operand
    for (int c = 0; c < 64; c++) begin
      step(1'b0, 13'h0000, 1'b1, 8'(c * 37 + 11));
      step(1'b1, 13'h1A80 + 13'(c), 1'b0, 8'h00);
    end
    // R6 page extremes
    step(1'b0, 13'h0, 1'b1, 8'hFF); step(1'b1, 13'h1AAF, 1'b0, 8'h00);
    step(1'b0, 13'h0, 1'b1, 8'h00); step(1'b1, 13'h1A8F, 1'b0, 8'h00);
    // R1: rejected codes and invalid strobe leave state (including pending prefix)
    step(1'b0, 13'h0, 1'b1, 8'h5A);
    step(1'b1, 13'h1A7F, 1'b0, 8'h00);
    step(1'b1, 13'h1AC0, 1'b0, 8'h00);
    step(1'b1, 13'h0000, 1'b0, 8'h00);
    step(1'b1, 13'h1FFF, 1'b0, 8'h00);
    step(1'b0, 13'h1A8F, 1'b0, 8'h00);
    step(1'b1, 13'h1A8F, 1'b0, 8'h00);
    // R8: prefix and instruction in the same cycle
    step(1'b1, 13'h1AAF, 1'b1, 8'h3C);
    step(1'b1, 13'h1AAF, 1'b1, 8'hC3);
    step(1'b1, 13'h1A8F, 1'b0, 8'h00);
    step(1'b1, 13'h1A8F, 1'b0, 8'h00);
    // R4: wrap of X through FFFFH
    while (m_x != 16'hFFFE) step(1'b1, 13'h1A9F, 1'b0, 8'h00);
    step(1'b1, 13'h1A9F, 1'b0, 8'h00);
    step(1'b1, 13'h1A9F, 1'b0, 8'h00);
    check(idx_x == 16'h0000, "R4", idx_x, 16'h0000);
    step(1'b1, 13'h1A93, 1'b0, 8'h00);
    // R9: reset mid-run with a pending prefix
    step(1'b0, 13'h0, 1'b1, 8'h77);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_x = '0; m_y = '0; m_z = 1'b0; m_e = 1'b0; m_op = '0;
    check_state("R9");
    step(1'b1, 13'h1A8F, 1'b0, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule